// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core with Upper-Immediate Load

This block is a compact single-cycle 32-bit processor. Each rising clock edge retires exactly one instruction. The decoded subset is register-register arithmetic and logic (add, subtract, and, or, set-less-than), word load, word store, branch-on-equal, and load-upper-immediate. The core holds a program counter, a 32-entry register file, an immediate generator, an ALU, a main decoder with an ALU-control decoder, and the next-PC and writeback selectors. Instruction and data storage are small internal word arrays.

Load-upper-immediate writes the instruction's top twenty bits, with twelve zero bits below them, into the destination register. A parameter picks how that value reaches writeback. The default takes it straight from the immediate generator into the writeback selector. The alternative steers it through the ALU as a pass-through of operand B.

A program port fills instruction storage. It is normally used while the core is held in reset. A debug port reads any register combinationally, so results can be inspected once a program has settled into a self-loop.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `pc_o` is 0 and every register reads 0 on the debug port.
- R2: An instruction with opcode bits[6:0]=7'b0110111 writes {inst[31:12], 12'b0} into the register named by bits[11:7]. Bits [19:15] have no effect. This holds for an all-ones upper field as well.
- R3: Opcode 7'b0110011 reads rs1 from bits[19:15] and rs2 from bits[24:20], and writes rd with the operation picked by funct3 bits[14:12] and bit 30: 000/0 add, 000/1 subtract, 111 and, 110 or, 010 signed set-less-than (1 or 0). A value written by load-upper-immediate is read correctly by the very next instruction.
- R4: Register x0 always reads 0. A write that names x0 changes no register.
- R5: Opcode 7'b0100011 with funct3 010 stores rs2 at word address (rs1 + sext({inst[31:25],inst[11:7]}))[7:2]. Opcode 7'b0000011 with funct3 010 loads that word into rd.
- R6: Opcode 7'b1100011 with rs1 equal to rs2 sets the next PC to PC + sext({inst[31],inst[7],inst[30:25],inst[11:8]}) shifted left by 1. If the two are not equal, the next PC is PC+4.
- R7: Every instruction other than a taken branch advances the PC by 4. That includes opcodes outside the subset, which also change no state.
- R8: A cycle with `prog_we` high writes `prog_data` into instruction word `prog_addr`. `dbg_rdata` shows register `dbg_raddr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_we | input | 1 | Instruction storage write enable |
| prog_addr | input | 6 | Instruction word address to write |
| prog_data | input | 32 | Instruction word to write |
| dbg_raddr | input | 5 | Register index to inspect |
| dbg_rdata | output | 32 | Contents of the inspected register |
| pc_o | output | 32 | Current program counter |

## Verification
The hardest case to reach from the ports is a load-upper-immediate result being consumed by the very next instruction. The only way to produce it is a program that runs freely. The stimulus therefore loads a short program during reset. In that program, upper-immediate writes with ordinary, all-ones and single-top-bit fields are followed at once by additions and logic that use them, and one such write targets x0. A taken branch skips an upper-immediate write, and a store/load round trip also appears. The program ends in a self-loop, so the final register contents and PC stay frozen for inspection through the debug port.

// File: rtl/sc_pkg.sv
package sc_pkg;
   localparam logic [6:0] OPC_ALU   = 7'b0110011;
   localparam logic [6:0] OPC_LOAD  = 7'b0000011;
   localparam logic [6:0] OPC_STORE = 7'b0100011;
   localparam logic [6:0] OPC_BEQ   = 7'b1100011;
   localparam logic [6:0] OPC_UPPER = 7'b0110111;

   typedef enum logic [1:0] {
      AOP_ADD, AOP_SUB, AOP_FUNCT, AOP_PASSB
   } aluop_e;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_PASSB
   } aluctl_e;

   typedef enum logic [1:0] {
      IMM_I, IMM_S, IMM_B, IMM_U
   } immsel_e;

   typedef struct packed {
      logic    reg_write;
      logic    alu_src;
      logic    branch;
      logic    mem_write;
      logic    mem_read;
      logic    mem_to_reg;
      logic    upper_sel;
      aluop_e  alu_op;
      immsel_e imm_sel;
   } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [6:0]    opcode,
   input  logic [2:0]    funct3,
   input  logic          alt_bit,
   output ctrl_t         ctrl,
   output aluctl_e       alu_ctl
);
   // main decoder
   always_comb begin
      ctrl = '{reg_write: 1'b0, alu_src: 1'b0, branch: 1'b0, mem_write: 1'b0,
               mem_read: 1'b0, mem_to_reg: 1'b0, upper_sel: 1'b0,
               alu_op: AOP_ADD, imm_sel: IMM_I};
      case (opcode)
         OPC_ALU: begin
            ctrl.reg_write = 1'b1;
            ctrl.alu_op    = AOP_FUNCT;
         end
         OPC_LOAD: begin
            ctrl.reg_write  = 1'b1;
            ctrl.alu_src    = 1'b1;
            ctrl.mem_read   = 1'b1;
            ctrl.mem_to_reg = 1'b1;
         end
         OPC_STORE: begin
            ctrl.alu_src   = 1'b1;
            ctrl.mem_write = 1'b1;
            ctrl.imm_sel   = IMM_S;
         end
         OPC_BEQ: begin
            ctrl.branch  = 1'b1;
            ctrl.alu_op  = AOP_SUB;
            ctrl.imm_sel = IMM_B;
         end
         OPC_UPPER: begin
            ctrl.reg_write = 1'b1;
            ctrl.alu_src   = 1'b1;
            ctrl.upper_sel = 1'b1;
            ctrl.alu_op    = AOP_PASSB;
            ctrl.imm_sel   = IMM_U;
         end
         default: ;
      endcase
   end

   // ALU control decoder
   always_comb begin
      case (ctrl.alu_op)
         AOP_ADD:   alu_ctl = ALU_ADD;
         AOP_SUB:   alu_ctl = ALU_SUB;
         AOP_PASSB: alu_ctl = ALU_PASSB;
         default: begin
            case (funct3)
               3'b000:  alu_ctl = alt_bit ? ALU_SUB : ALU_ADD;
               3'b111:  alu_ctl = ALU_AND;
               3'b110:  alu_ctl = ALU_OR;
               3'b010:  alu_ctl = ALU_SLT;
               default: alu_ctl = ALU_ADD;
            endcase
         end
      endcase
   end

   // R5 R6
   // at most one of load, store, branch per instruction
   mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ctrl.mem_write, ctrl.mem_read, ctrl.branch}));

   // R5
   // a store never writes the register file
   store_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.mem_write |-> !ctrl.reg_write);
endmodule

// File: rtl/sc_immgen.sv
module sc_immgen
   import sc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:7]      inst_hi,
   input  immsel_e          sel,
   output logic [XLEN-1:0]  imm
);
   localparam int SEXT_I = XLEN - 12;
   localparam int ZPAD_U = 12;

   always_comb begin
      case (sel)
         IMM_S:   imm = {{SEXT_I{inst_hi[31]}}, inst_hi[31:25], inst_hi[11:7]};
         IMM_B:   imm = {{SEXT_I{inst_hi[31]}}, inst_hi[31], inst_hi[7],
                         inst_hi[30:25], inst_hi[11:8]};
         IMM_U:   imm = {inst_hi[31:12], {ZPAD_U{1'b0}}};
         default: imm = {{SEXT_I{inst_hi[31]}}, inst_hi[31:20]};
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0]  op_a,
   input  logic [XLEN-1:0]  op_b,
   input  aluctl_e          ctl,
   output logic [XLEN-1:0]  result,
   output logic             zero
);
   always_comb begin
      case (ctl)
         ALU_SUB:   result = op_a - op_b;
         ALU_AND:   result = op_a & op_b;
         ALU_OR:    result = op_a | op_b;
         ALU_SLT:   result = {{(XLEN-1){1'b0}}, $signed(op_a) < $signed(op_b)};
         ALU_PASSB: result = op_b;
         default:   result = op_a + op_b;
      endcase
   end
   assign zero = (result == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int XLEN = 32,
   parameter int AW   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [XLEN-1:0]  wdata,
   input  logic [AW-1:0]    ra1,
   output logic [XLEN-1:0]  rd1,
   input  logic [AW-1:0]    ra2,
   output logic [XLEN-1:0]  rd2,
   input  logic [AW-1:0]    ra3,
   output logic [XLEN-1:0]  rd3
);
   localparam int NREGS = 1 << AW;

   logic [NREGS-1:0][XLEN-1:0] regs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs <= '0;
      end else if (we && (waddr != '0)) begin
         regs[waddr] <= wdata;
      end
   end

   assign rd1 = regs[ra1];
   assign rd2 = regs[ra2];
   assign rd3 = regs[ra3];

   // R4
   x0_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == '0) |=> (regs == $past(regs)));

   // R2 R3
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr != '0) |=> (rd3 == $past(wdata)) || (ra3 != $past(waddr)));
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int REG_AW     = 5,
   parameter int IMEM_AW    = 6,
   parameter int DMEM_AW    = 6,
   parameter bit UPPER_BYPASS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                prog_we,
   input  logic [IMEM_AW-1:0]  prog_addr,
   input  logic [31:0]         prog_data,
   input  logic [REG_AW-1:0]   dbg_raddr,
   output logic [XLEN-1:0]     dbg_rdata,
   output logic [XLEN-1:0]     pc_o
);
   localparam int IMEM_WORDS = 1 << IMEM_AW;
   localparam int DMEM_WORDS = 1 << DMEM_AW;
   localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

   initial begin
      assert (XLEN == 32) else $error("XLEN must be 32");
      assert (REG_AW == 5) else $error("REG_AW must be 5");
      assert (IMEM_AW >= 2 && IMEM_AW <= 10) else $error("IMEM_AW out of range");
      assert (DMEM_AW >= 2 && DMEM_AW <= 10) else $error("DMEM_AW out of range");
   end

   logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target;
   logic [31:0]     inst;
   logic [31:0]     imem [IMEM_WORDS];
   logic [XLEN-1:0] dmem [DMEM_WORDS];
   ctrl_t           ctrl;
   aluctl_e         alu_ctl;
   logic [XLEN-1:0] imm, rs1_val, rs2_val, op_b, alu_y, load_val, wb_data;
   logic            alu_zero, br_taken;

   // instruction storage, program port
   always_ff @(posedge clk) begin
      if (prog_we) imem[prog_addr] <= prog_data;
   end
   assign inst = imem[pc_q[IMEM_AW+1:2]];

   // program counter
   assign pc_plus4  = pc_q + PC_STEP;
   assign br_target = pc_q + {imm[XLEN-2:0], 1'b0};
   assign br_taken  = ctrl.branch & alu_zero;
   assign pc_next   = br_taken ? br_target : pc_plus4;

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_next;
   end
   assign pc_o = pc_q;

   sc_decode i_decode (
      .clk     (clk),
      .rst_n   (rst_n),
      .opcode  (inst[6:0]),
      .funct3  (inst[14:12]),
      .alt_bit (inst[30]),
      .ctrl    (ctrl),
      .alu_ctl (alu_ctl)
   );

   sc_immgen #(.XLEN(XLEN)) i_immgen (
      .inst_hi (inst[31:7]),
      .sel     (ctrl.imm_sel),
      .imm     (imm)
   );

   sc_regfile #(.XLEN(XLEN), .AW(REG_AW)) i_regfile (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctrl.reg_write),
      .waddr (inst[11:7]),
      .wdata (wb_data),
      .ra1   (inst[19:15]),
      .rd1   (rs1_val),
      .ra2   (inst[24:20]),
      .rd2   (rs2_val),
      .ra3   (dbg_raddr),
      .rd3   (dbg_rdata)
   );

   assign op_b = ctrl.alu_src ? imm : rs2_val;

   sc_alu #(.XLEN(XLEN)) i_alu (
      .op_a   (rs1_val),
      .op_b   (op_b),
      .ctl    (alu_ctl),
      .result (alu_y),
      .zero   (alu_zero)
   );

   // data storage, word addressed
   always_ff @(posedge clk) begin
      if (rst_n && ctrl.mem_write) dmem[alu_y[DMEM_AW+1:2]] <= rs2_val;
   end
   assign load_val = dmem[alu_y[DMEM_AW+1:2]];

   // writeback: upper immediate either bypasses the ALU or passes through it
   generate
      if (UPPER_BYPASS) begin : g_upper_bypass
         always_comb begin
            if (ctrl.upper_sel)      wb_data = imm;
            else if (ctrl.mem_to_reg) wb_data = load_val;
            else                      wb_data = alu_y;
         end
      end else begin : g_upper_via_alu
         always_comb begin
            if (ctrl.mem_to_reg) wb_data = load_val;
            else                 wb_data = alu_y;
         end
      end
   endgenerate

   // R7
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !br_taken |=> (pc_q == $past(pc_q) + PC_STEP));

   // R6
   branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |=> (pc_q == $past(pc_q) + {$past(imm[XLEN-2:0]), 1'b0}));

   // R6
   branch_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_taken |-> (rs1_val == rs2_val));

   // R2
   upper_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inst[6:0] == OPC_UPPER) |-> (ctrl.reg_write && wb_data == {inst[31:12], 12'b0}));
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prog_we = 1'b0;
   logic [5:0]  prog_addr = '0;
   logic [31:0] prog_data = '0;
   logic [4:0]  dbg_raddr = '0;
   logic [31:0] dbg_rdata;
   logic [31:0] pc_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   sc_core i_sc_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_we   (prog_we),
      .prog_addr (prog_addr),
      .prog_data (prog_data),
      .dbg_raddr (dbg_raddr),
      .dbg_rdata (dbg_rdata),
      .pc_o      (pc_o)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd_reg(input int idx, output logic [31:0] v);
      dbg_raddr = 5'(idx);
      #1;
      v = dbg_rdata;
   endtask

   task automatic chk_reg(string req, int idx, logic [31:0] exp);
      logic [31:0] v;
      rd_reg(idx, v);
      chk(req, v, exp);
   endtask

   function automatic logic [31:0] enc_u(logic [19:0] hi, logic [4:0] rd);
      return {hi, rd, 7'b0110111};
   endfunction
   function automatic logic [31:0] enc_r(logic alt, logic [4:0] rs2, logic [4:0] rs1,
                                         logic [2:0] f3, logic [4:0] rd);
      return {1'b0, alt, 5'b0, rs2, rs1, f3, rd, 7'b0110011};
   endfunction
   function automatic logic [31:0] enc_lw(logic [11:0] off, logic [4:0] rs1, logic [4:0] rd);
      return {off, rs1, 3'b010, rd, 7'b0000011};
   endfunction
   function automatic logic [31:0] enc_sw(logic [11:0] off, logic [4:0] rs2, logic [4:0] rs1);
      return {off[11:5], rs2, rs1, 3'b010, off[4:0], 7'b0100011};
   endfunction
   function automatic logic [31:0] enc_beq(logic [12:0] off, logic [4:0] rs2, logic [4:0] rs1);
      return {off[12], off[10:5], rs2, rs1, 3'b000, off[4:1], off[11], 7'b1100011};
   endfunction

   task automatic load_word(int addr, logic [31:0] w);
      @(negedge clk);
      prog_we   = 1'b1;
      prog_addr = 6'(addr);
      prog_data = w;
      @(negedge clk);
      prog_we   = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 pc in reset", pc_o, 32'h0);
      for (int i = 0; i < 32; i += 7) chk_reg("R1 reg in reset", i, 32'h0);
   endtask

   task automatic t_load_program;
      for (int a = 0; a < 64; a++) load_word(a, 32'h0);
      load_word(0,  enc_u(20'h12345, 5'd1));
      load_word(1,  enc_u(20'hFFFFF, 5'd2));
      load_word(2,  enc_u(20'h00001, 5'd3));
      load_word(3,  enc_r(1'b0, 5'd3, 5'd1, 3'b000, 5'd4));
      load_word(4,  enc_r(1'b0, 5'd2, 5'd2, 3'b000, 5'd5));
      load_word(5,  enc_u(20'hABCDE, 5'd0));
      load_word(6,  enc_sw(12'd8, 5'd1, 5'd0));
      load_word(7,  enc_lw(12'd8, 5'd0, 5'd6));
      load_word(8,  enc_r(1'b1, 5'd3, 5'd1, 3'b000, 5'd7));
      load_word(9,  enc_beq(13'd8, 5'd4, 5'd4));
      load_word(10, enc_u(20'hDEAD0, 5'd8));
      load_word(11, enc_beq(13'd8, 5'd3, 5'd1));
      load_word(12, enc_u(20'h80000, 5'd9));
      load_word(13, enc_r(1'b0, 5'd1, 5'd2, 3'b111, 5'd10));
      load_word(14, enc_r(1'b0, 5'd1, 5'd2, 3'b010, 5'd11));
      load_word(15, enc_r(1'b0, 5'd3, 5'd1, 3'b110, 5'd12));
      load_word(16, 32'h0000_0000);
      load_word(17, enc_beq(13'd0, 5'd0, 5'd0));
   endtask

   task automatic t_first_cycles;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 pc just after reset", pc_o, 32'h0);
      @(negedge clk);
      chk("R7 pc after one step", pc_o, 32'h4);
      chk_reg("R2 first upper write", 1, 32'h1234_5000);
      @(negedge clk);
      chk("R7 pc after two steps", pc_o, 32'h8);
   endtask

   task automatic t_upper_values;
      chk_reg("R2 ordinary field", 1, 32'h1234_5000);
      chk_reg("R2 all-ones field", 2, 32'hFFFF_F000);
      chk_reg("R2 low field bit", 3, 32'h0000_1000);
      chk_reg("R2 top bit only", 9, 32'h8000_0000);
   endtask

   task automatic t_alu_after_upper;
      chk_reg("R3 add after upper", 4, 32'h1234_6000);
      chk_reg("R3 add of all-ones upper", 5, 32'hFFFF_E000);
      chk_reg("R3 subtract", 7, 32'h1234_4000);
      chk_reg("R3 and", 10, 32'h1234_5000);
      chk_reg("R3 slt signed", 11, 32'h0000_0001);
      chk_reg("R3 or", 12, 32'h1234_5000);
   endtask

   task automatic t_x0;
      chk_reg("R4 x0 after write attempt", 0, 32'h0);
   endtask

   task automatic t_memory;
      chk_reg("R5 store then load", 6, 32'h1234_5000);
   endtask

   task automatic t_branch;
      chk_reg("R6 skipped by taken branch", 8, 32'h0);
      chk("R6 self-loop pc", pc_o, 32'd68);
      @(negedge clk);
      chk("R6 self-loop holds", pc_o, 32'd68);
   endtask

   task automatic t_debug_port;
      logic [31:0] v;
      rd_reg(2, v);
      chk("R8 debug read x2", v, 32'hFFFF_F000);
      rd_reg(31, v);
      chk("R8 debug read untouched x31", v, 32'h0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      t_reset;
      t_load_program;
      t_first_cycles;
      repeat (40) @(negedge clk);
      t_upper_values;
      t_alu_after_upper;
      t_x0;
      t_memory;
      t_branch;
      t_debug_port;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule